// File: doc/BRIEF.md
# Serial-to-Byte Receive FIFO

This block sits behind a serial demodulator. Each cycle in which the bit-clock enable is high, it takes one received bit into an 8-bit shift register. After every eighth such bit, it moves the completed byte into a byte-wide FIFO. The usable depth of the FIFO is picked at run time from four sizes.

A host drains the FIFO through a read port framed by an active-low select. Each falling edge of the select takes out the oldest stored byte and presents it on the read data bus. The select is sampled synchronously to the block clock.

The block drives five status outputs:
- an active-low not-empty flag, which is only lowered at a read;
- a full flag;
- a byte-written pulse one bit period long;
- a comparison of the fill level against a programmable threshold;
- a sticky overrun flag. Pulsing the overrun-clear input clears this flag and discards the whole FIFO content.

Top module: `serial_rx_fifo`

## Requirements
- R1: Bits are taken only in cycles with `bit_en` high. The first bit of each group of eight becomes bit 7 (MSB) of the byte, and the eighth becomes bit 0. The byte is offered to the FIFO on the clock edge that takes its eighth bit.
- R2: A falling edge of `rd_sel_n` is seen when `rd_sel_n` is low at a clock edge and was high at the previous edge. If the FIFO holds at least one byte, the oldest byte is removed and appears on `rd_data` after that edge. Otherwise `rd_data` keeps its value.
- R3: `empty_n` goes high on the edge that stores a byte. It goes low only on a read falling edge that leaves the FIFO with no bytes, on an overrun clear, or on reset. Otherwise it holds its value.
- R4: `byte_wr` goes high on the edge that stores a byte and stays high until the next edge with `bit_en` high, which is one bit period. A dropped byte does not raise it.
- R5: `depth_sel` selects the depth: 0 gives 16 bytes, 1 gives 32, 2 gives 48 and 3 gives 64. `full` is high when the stored byte count equals the selected depth. The depth is changed only while the FIFO is empty.
- R6: A byte completed while the FIFO is full, with no read falling edge in the same cycle, is discarded and sets `overrun`. The flag then stays high until cleared. A read falling edge in the same cycle makes room, so the byte is stored instead.
- R7: `ovr_clr` high at an edge does four things: it clears `overrun`, empties the FIFO, drives `empty_n` low, and discards any byte completed in that same cycle.
- R8: `thr_hit` is high when the stored byte count is greater than or equal to `thresh`, and low otherwise.
- R9: `rst_n` low at a clock edge clears the FIFO, the shift register (bit position back to the first bit), `rd_data`, `empty_n`, `byte_wr` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; `bit_in` is valid in this cycle |
| bit_in | input | 1 | Received serial bit |
| depth_sel | input | 2 | Selected depth: (value+1)*16 bytes |
| thresh | input | 7 | Threshold level compared with the fill count |
| rd_sel_n | input | 1 | Read select, active low; its falling edge pops a byte |
| rd_data | output | 8 | Last byte popped |
| ovr_clr | input | 1 | Write-one pulse: clears overrun and flushes the FIFO |
| empty_n | output | 1 | Low when no byte is stored, updated as in R3 |
| full | output | 1 | High when the count equals the selected depth |
| byte_wr | output | 1 | One-bit-period pulse per stored byte |
| thr_hit | output | 1 | Count is greater than or equal to `thresh` |
| overrun | output | 1 | Sticky flag for a dropped byte |

## Verification
A byte can complete on the same edge that the host's read falling edge is detected. When the FIFO is full, this decides between storing the byte and an overrun. The bench lines up the eighth bit of a byte with the select dropping, both on a full FIFO and on an empty one. It then judges `full`, `overrun`, `empty_n` and the popped byte against a queue model.

A byte that completes in the same cycle as an overrun clear is provoked the same way. The check is that both the byte and the flag are gone.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int BYTE_W          = 8;
    localparam int DEF_MAX_DEPTH   = 64;
    localparam int DEF_SIZE_COUNT  = 4;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/srf_shifter.sv
module srf_shifter #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic         byte_vld,
    output logic [W-1:0] byte_out
);
    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] pos;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        byte_out = {s_q.sr[W-2:0], bit_in};
        byte_vld = bit_en && (s_q.pos == CW'(W-1));
        if (bit_en) begin
            s_d.sr  = {s_q.sr[W-2:0], bit_in};
            s_d.pos = (s_q.pos == CW'(W-1)) ? '0 : s_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/srf_store.sv
module srf_store #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_word
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import srf_pkg::*;
#(
    parameter int  MAX_DEPTH  = DEF_MAX_DEPTH,
    parameter int  SIZE_COUNT = DEF_SIZE_COUNT,
    localparam int SEL_W      = $clog2(SIZE_COUNT),
    localparam int CNT_W      = $clog2(MAX_DEPTH + 1),
    localparam int PTR_W      = $clog2(MAX_DEPTH),
    localparam int STEP       = MAX_DEPTH / SIZE_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic [SEL_W-1:0] depth_sel,
    input  logic [CNT_W-1:0] thresh,
    input  logic             rd_sel_n,
    output logic [BYTE_W-1:0] rd_data,
    input  logic             ovr_clr,
    output logic             empty_n,
    output logic             full,
    output logic             byte_wr,
    output logic             thr_hit,
    output logic             overrun
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
        byte_t            rd_data;
        logic             empty_n;
        logic             byte_wr;
        logic             overrun;
        logic             sel_prev;
    } ctl_state_t;

    localparam ctl_state_t RESET_STATE = '{
        wr_ptr: '0, rd_ptr: '0, count: '0, rd_data: '0,
        empty_n: 1'b0, byte_wr: 1'b0, overrun: 1'b0, sel_prev: 1'b1
    };

    ctl_state_t r_d, r_q;

    logic             new_vld;
    byte_t            new_byte;
    byte_t            head_byte;
    logic [CNT_W-1:0] depth;
    logic [CNT_W-1:0] level;
    logic             sel_fall, do_pop, do_push, has_room;

    srf_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .byte_vld (new_vld),
        .byte_out (new_byte)
    );

    srf_store #(.W(BYTE_W), .DEPTH(MAX_DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_addr (r_q.wr_ptr),
        .wr_data (new_byte),
        .rd_addr (r_q.rd_ptr),
        .rd_word (head_byte)
    );

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] lim);
        return (CNT_W'(p) == lim - 1'b1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        depth    = CNT_W'((int'(depth_sel) + 1) * STEP);
        level    = r_q.count;
        sel_fall = r_q.sel_prev && !rd_sel_n;
        do_pop   = sel_fall && (r_q.count != '0) && !ovr_clr;
        has_room = (r_q.count < depth) || do_pop;
        do_push  = new_vld && has_room && !ovr_clr;

        r_d          = r_q;
        r_d.sel_prev = rd_sel_n;

        if (ovr_clr) begin
            r_d.wr_ptr  = '0;
            r_d.rd_ptr  = '0;
            r_d.count   = '0;
            r_d.empty_n = 1'b0;
            r_d.overrun = 1'b0;
        end else begin
            if (do_pop) begin
                r_d.rd_data = head_byte;
                r_d.rd_ptr  = ptr_next(r_q.rd_ptr, depth);
            end
            if (do_push) begin
                r_d.wr_ptr = ptr_next(r_q.wr_ptr, depth);
            end
            r_d.count = r_q.count + CNT_W'(do_push) - CNT_W'(do_pop);
            if (new_vld && !has_room) begin
                r_d.overrun = 1'b1;
            end
            if (sel_fall) r_d.empty_n = (r_d.count != '0);
            else          r_d.empty_n = r_q.empty_n | do_push;
        end

        if (bit_en) r_d.byte_wr = do_push;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_STATE;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rd_data;
    assign empty_n = r_q.empty_n;
    assign byte_wr = r_q.byte_wr;
    assign overrun = r_q.overrun;
    assign full    = (r_q.count >= depth);
    assign thr_hit = (r_q.count >= thresh);
endmodule

module srf_checker #(
    parameter int CNT_W     = 7,
    parameter int MAX_DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             rd_sel_n,
    input logic             ovr_clr,
    input logic             empty_n,
    input logic             full,
    input logic             byte_wr,
    input logic             overrun,
    input logic [CNT_W-1:0] level
);
    logic sel_seen;
    logic fall;

    always_ff @(posedge clk) begin
        if (!rst_n) sel_seen <= 1'b1;
        else        sel_seen <= rd_sel_n;
    end
    assign fall = sel_seen && !rd_sel_n;

    // R3: not-empty only drops at a read edge or a flush
    a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_n && !fall && !ovr_clr) |=> empty_n);

    // R4: pulse ends at the next enabled bit
    a_r4_pulse_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && bit_en) |=> !byte_wr);

    // R4: a stored byte leaves the FIFO not empty
    a_r4_pulse_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_wr) |-> empty_n);

    // R6: a full FIFO without a read never grows or shrinks
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !fall && !ovr_clr) |=> (level == $past(level)));

    // R6: overrun is sticky
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R7: clearing flushes everything
    a_r7_clear_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> (!overrun && !empty_n && level == '0));

    // R5: count never exceeds the largest depth
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(MAX_DEPTH));
endmodule

bind serial_rx_fifo srf_checker #(.CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rd_sel_n (rd_sel_n),
    .ovr_clr  (ovr_clr),
    .empty_n  (empty_n),
    .full     (full),
    .byte_wr  (byte_wr),
    .overrun  (overrun),
    .level    (level)
);

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_in = 1'b0;
    logic [1:0] depth_sel = 2'd0;
    logic [6:0] thresh = 7'd5;
    logic       rd_sel_n = 1'b1, ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       empty_n, full, byte_wr, thr_hit, overrun;

    int n_chk = 0, n_err = 0;
    bit done = 0, started = 0;

    always #5 clk = ~clk;

    serial_rx_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .depth_sel(depth_sel), .thresh(thresh), .rd_sel_n(rd_sel_n),
        .rd_data(rd_data), .ovr_clr(ovr_clr), .empty_n(empty_n),
        .full(full), .byte_wr(byte_wr), .thr_hit(thr_hit), .overrun(overrun)
    );

    // behavioural reference model
    logic [7:0] q[$];
    logic [7:0] m_sr, m_rd;
    int         m_nb;
    logic       m_prev, m_empty_n, m_bw, m_ovr;

    always @(posedge clk) begin
        bit fall, got, stored;
        int dep;
        if (!rst_n) begin
            q.delete(); m_sr = 0; m_nb = 0; m_rd = 0;
            m_prev = 1; m_empty_n = 0; m_bw = 0; m_ovr = 0;
        end else begin
            fall = m_prev && !rd_sel_n;
            m_prev = rd_sel_n;
            got = 0; stored = 0;
            dep = (int'(depth_sel) + 1) * 16;
            if (bit_en) begin
                m_sr = {m_sr[6:0], bit_in};
                m_nb++;
                if (m_nb == 8) begin got = 1; m_nb = 0; end
            end
            if (ovr_clr) begin
                q.delete(); m_ovr = 0; m_empty_n = 0;
            end else begin
                if (fall && q.size() > 0) m_rd = q.pop_front();
                if (got) begin
                    if (q.size() < dep) begin q.push_back(m_sr); stored = 1; end
                    else m_ovr = 1;
                end
                if (fall) m_empty_n = (q.size() != 0);
                else if (stored) m_empty_n = 1;
            end
            if (bit_en) m_bw = stored;
        end
        started = 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int dep;
        if (started && !done) begin
            dep = (int'(depth_sel) + 1) * 16;
            chk(rd_data === m_rd,        "R2 rd_data", int'(rd_data), int'(m_rd));
            chk(empty_n === m_empty_n,   "R3 empty_n", int'(empty_n), int'(m_empty_n));
            chk(byte_wr === m_bw,        "R4 byte_wr", int'(byte_wr), int'(m_bw));
            chk(full === (q.size() >= dep), "R5 full", int'(full), int'(q.size() >= dep));
            chk(overrun === m_ovr,       "R6 overrun", int'(overrun), int'(m_ovr));
            chk(thr_hit === (q.size() >= int'(thresh)), "R8 thr_hit",
                int'(thr_hit), int'(q.size() >= int'(thresh)));
        end
    end

    task automatic cyc(input logic en, input logic b, input logic sel_n, input logic clr);
        bit_en = en; bit_in = b; rd_sel_n = sel_n; ovr_clr = clr;
        @(negedge clk); #1;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit rd_last, input bit clr_last,
                             input bit gaps);
        for (int i = 0; i < 8; i++) begin
            if (gaps) cyc(0, 0, 1, 0);
            cyc(1, v[7-i], (i == 7 && rd_last) ? 1'b0 : 1'b1, (i == 7) && clr_last);
        end
        cyc(0, 0, 1, 0);
    endtask

    task automatic read_one();
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 0);
    endtask

    task automatic flush();
        cyc(0, 0, 1, 1);
        cyc(0, 0, 1, 0);
    endtask

    task automatic random_run(input int cycles, input int rd_div);
        for (int i = 0; i < cycles; i++) begin
            if ($urandom % 97 == 0) thresh = 7'($urandom % 70);
            cyc(1'($urandom % 2), 1'($urandom % 2), ($urandom % rd_div) != 0,
                ($urandom % 300) == 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk(empty_n === 0 && full === 0 && byte_wr === 0 && overrun === 0 && rd_data === 0,
            "R9 reset outputs", {empty_n, full, byte_wr, overrun}, 0);
        rst_n = 1;
        cyc(0, 0, 1, 0);

        // R1: MSB first, with gaps between bits
        send_byte(8'hA5, 0, 0, 1);
        chk(empty_n === 1, "R3 not empty after store", int'(empty_n), 1);
        send_byte(8'h3C, 0, 0, 0);
        send_byte(8'h81, 0, 0, 0);
        read_one();
        chk(rd_data === 8'hA5, "R1 first byte msb first", int'(rd_data), 8'hA5);
        read_one(); read_one();
        chk(rd_data === 8'h81, "R2 oldest order", int'(rd_data), 8'h81);
        chk(empty_n === 0, "R3 empty after last read", int'(empty_n), 0);
        read_one();
        chk(rd_data === 8'h81, "R2 read on empty keeps data", int'(rd_data), 8'h81);

        // R5 R6 R8: fill each depth, overflow, then coincident cases
        for (int d = 0; d < 4; d++) begin
            depth_sel = 2'(d);
            thresh = 7'((d + 1) * 16 - 3);
            for (int k = 0; k < (d + 1) * 16; k++) send_byte(8'(k * 7 + d), 0, 0, 0);
            chk(full === 1, "R5 full at depth", int'(full), 1);
            chk(thr_hit === 1, "R8 threshold reached", int'(thr_hit), 1);
            send_byte(8'hEE, 0, 0, 0);
            chk(overrun === 1, "R6 overrun on full", int'(overrun), 1);
            // byte completes on the read edge: stored, no new drop
            send_byte(8'h5A, 1, 0, 0);
            chk(full === 1, "R6 read edge makes room", int'(full), 1);
            // byte completes together with clear: flushed and lost
            send_byte(8'h77, 0, 1, 0);
            chk(overrun === 0 && empty_n === 0, "R7 clear flushes", {overrun, empty_n}, 0);
            read_one();
            chk(empty_n === 0, "R7 no byte survives", int'(empty_n), 0);
        end

        // byte completes on a read edge of an empty FIFO
        depth_sel = 2'd0;
        send_byte(8'hC3, 1, 0, 0);
        chk(empty_n === 1, "R3 store and read edge on empty", int'(empty_n), 1);
        flush();

        // random mixes, depth changed only after a flush
        for (int d = 0; d < 4; d++) begin
            flush();
            depth_sel = 2'(d);
            random_run(1500, 3);
            flush();
            random_run(2500, 60);
        end

        // R9: reset mid-stream
        send_byte(8'h12, 0, 0, 0);
        bit_en = 1; bit_in = 1; @(negedge clk); #1;
        rst_n = 0; cyc(0, 0, 1, 0);
        chk(empty_n === 0 && overrun === 0, "R9 reset clears", {empty_n, overrun}, 0);
        rst_n = 1;
        send_byte(8'h96, 0, 0, 0);
        read_one();
        chk(rd_data === 8'h96, "R9 shift position reset", int'(rd_data), 8'h96);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule